// File: doc/BRIEF.md
# Overlay Memory Address Decoder

This block turns a 14-bit processor address into a memory target for two separate address spaces, program (PM) and data (DM). Each space has one fixed 8K internal segment and one 8K window. What the window shows depends on a per-space overlay code held in a register. For every requested access the block raises exactly one of three enables: internal RAM, external memory or memory-mapped register. It also supplies the address that goes with that enable: an internal page index and offset, an external upper address pin and low address lines, or a register index.

The two overlay registers live in the block. Each has its own load strobe and both take data from a shared input. A load changes the register on the next clock edge, and that register reset to code 0. Decoding of an access is combinational, so a request and its result fall in the same cycle. The RAM arrays, arbitration and wait states sit outside the block.

Top module: `ovl_addr_decoder`

## Requirements
- R1: A PM access to 0x0000..0x1FFF raises int_en with int_page = 0 and int_addr = addr[12:0], whatever the PM overlay code.
- R2: A DM access to 0x2000..0x3FDF raises int_en with int_page = 0 and int_addr = addr[12:0], whatever the DM overlay code.
- R3: A DM access to 0x3FE0..0x3FFF raises reg_en with reg_idx = addr[4:0] and no other enable.
- R4: A window access (PM 0x2000..0x3FFF, DM 0x0000..0x1FFF) with overlay code 0, 4 or 5 raises int_en with int_page 1, 2 or 3 respectively, and int_addr = addr[12:0].
- R5: A window access with overlay code 1 or 2 raises ext_en with ext_addr = addr[12:0], and ext_a13 = 0 for code 1 and 1 for code 2.
- R6: A window access with any other overlay code raises bad_ovl and no enable.
- R7: At most one of int_en, ext_en, reg_en is high. With req low, every output is 0. Every address output that does not belong to the raised enable is 0.
- R8: Both overlay codes are 0 after reset. ld_pm (ld_dm) loads ovl_din into the PM (DM) code at the next rising clock edge. The new code is in effect from then on.
- R9: mem_wr equals wr while any enable is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the overlay registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_pm | input | 1 | Load PM overlay code from ovl_din |
| ld_dm | input | 1 | Load DM overlay code from ovl_din |
| ovl_din | input | 4 | Overlay code to load |
| req | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| space_dm | input | 1 | 0 = program space, 1 = data space |
| addr | input | 14 | Processor address |
| int_en | output | 1 | Internal RAM selected |
| ext_en | output | 1 | External memory selected |
| reg_en | output | 1 | Memory-mapped register selected |
| bad_ovl | output | 1 | Window access with an unmapped overlay code |
| mem_wr | output | 1 | Write strobe for the selected target |
| int_page | output | 2 | 0 fixed segment, 1..3 overlay pages |
| int_addr | output | 13 | Offset inside the internal page |
| ext_a13 | output | 1 | External upper address pin |
| ext_addr | output | 13 | External low address lines |
| reg_idx | output | 5 | Register index |

## Verification
The hardest situation to reach is a window access made in the first cycle after an overlay load, with the other space's code deliberately different. It is hard because a load that takes effect one edge late, or lands in the wrong register, only shows up when an access follows it at once. The stimulus loads each code from 0 to 15 into one space, then accesses both windows in the very next cycle. It also crosses the fixed-segment boundaries and the register boundary at 0x3FDF/0x3FE0.

// File: rtl/ovl_addr_decoder.sv
module ovl_addr_decoder #(
  parameter int AW = 14,
  parameter int OW = 4,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_pm,
  input  logic          ld_dm,
  input  logic [OW-1:0] ovl_din,
  input  logic          req,
  input  logic          wr,
  input  logic          space_dm,
  input  logic [AW-1:0] addr,
  output logic          int_en,
  output logic          ext_en,
  output logic          reg_en,
  output logic          bad_ovl,
  output logic          mem_wr,
  output logic [1:0]    int_page,
  output logic [AW-2:0] int_addr,
  output logic          ext_a13,
  output logic [AW-2:0] ext_addr,
  output logic [RW-1:0] reg_idx
);
  localparam int SW = AW - 1;
  localparam logic [AW-1:0] REG_BASE = AW'((1 << AW) - (1 << RW));
  localparam logic [OW-1:0] C_INT0 = OW'(0);
  localparam logic [OW-1:0] C_EXT1 = OW'(1);
  localparam logic [OW-1:0] C_EXT2 = OW'(2);
  localparam logic [OW-1:0] C_INT4 = OW'(4);
  localparam logic [OW-1:0] C_INT5 = OW'(5);

  logic [OW-1:0] pm_q, dm_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pm_q <= '0;
      dm_q <= '0;
    end else begin
      if (ld_pm) pm_q <= ovl_din;
      if (ld_dm) dm_q <= ovl_din;
    end

  logic          in_win, in_reg;
  logic [OW-1:0] code;

  assign in_win = space_dm ? ~addr[AW-1] : addr[AW-1];
  assign in_reg = space_dm && (addr >= REG_BASE);
  assign code   = space_dm ? dm_q : pm_q;

  always_comb begin
    int_en   = 1'b0;
    ext_en   = 1'b0;
    reg_en   = 1'b0;
    bad_ovl  = 1'b0;
    int_page = 2'd0;
    ext_a13  = 1'b0;
    if (req) begin
      if (in_reg) reg_en = 1'b1;
      else if (!in_win) int_en = 1'b1;
      else begin
        unique case (code)
          C_INT0:  begin int_en = 1'b1; int_page = 2'd1; end
          C_INT4:  begin int_en = 1'b1; int_page = 2'd2; end
          C_INT5:  begin int_en = 1'b1; int_page = 2'd3; end
          C_EXT1:  ext_en = 1'b1;
          C_EXT2:  begin ext_en = 1'b1; ext_a13 = 1'b1; end
          default: bad_ovl = 1'b1;
        endcase
      end
    end
  end

  assign int_addr = int_en ? addr[SW-1:0] : '0;
  assign ext_addr = ext_en ? addr[SW-1:0] : '0;
  assign reg_idx  = reg_en ? addr[RW-1:0] : '0;
  assign mem_wr   = wr && (int_en || ext_en || reg_en);

  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_en, ext_en, reg_en}));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !(int_en || ext_en || reg_en || bad_ovl || mem_wr));
  a_r6_bad_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    bad_ovl |-> !(int_en || ext_en || reg_en));
  a_r1_pm_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !space_dm && !addr[AW-1]) |-> (int_en && int_page == 2'd0));
  a_r3_dm_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (req && space_dm && (&addr[AW-1:RW])) |-> (reg_en && !int_en && !ext_en));
  a_r8_pm_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pm |=> pm_q == $past(ovl_din));
  a_r8_dm_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_dm |=> dm_q == $past(ovl_din));
  a_r9_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (wr && req));
endmodule

// File: tb/ovl_addr_decoder_tb.sv
module ovl_addr_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_pm = 0, ld_dm = 0, req = 0, wr = 0, space_dm = 0;
  logic [3:0] ovl_din = '0;
  logic [13:0] addr = '0;
  logic int_en, ext_en, reg_en, bad_ovl, mem_wr, ext_a13;
  logic [1:0] int_page;
  logic [12:0] int_addr, ext_addr;
  logic [4:0] reg_idx;

  int n_chk = 0, n_fail = 0;
  int m_pm = 0, m_dm = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ovl_addr_decoder u_dut (.clk, .rst_n, .ld_pm, .ld_dm, .ovl_din, .req, .wr,
    .space_dm, .addr, .int_en, .ext_en, .reg_en, .bad_ovl, .mem_wr, .int_page,
    .int_addr, .ext_a13, .ext_addr, .reg_idx);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (dm=%0d addr=%0h pm=%0d dmc=%0d)",
               tag, act, exp, space_dm, addr, m_pm, m_dm);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin m_pm = 0; m_dm = 0; end
    else begin
      if (ld_pm) m_pm = ovl_din;
      if (ld_dm) m_dm = ovl_din;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int a, code, e_int, e_ext, e_reg, e_bad, e_pg, e_a13;
    bit win;
    a = addr; code = space_dm ? m_dm : m_pm;
    e_int = 0; e_ext = 0; e_reg = 0; e_bad = 0; e_pg = 0; e_a13 = 0;
    win = space_dm ? (a < 'h2000) : (a >= 'h2000);
    if (req) begin
      if (space_dm && a >= 'h3FE0) e_reg = 1;
      else if (!win) e_int = 1;
      else if (code == 0) begin e_int = 1; e_pg = 1; end
      else if (code == 4) begin e_int = 1; e_pg = 2; end
      else if (code == 5) begin e_int = 1; e_pg = 3; end
      else if (code == 1) e_ext = 1;
      else if (code == 2) begin e_ext = 1; e_a13 = 1; end
      else e_bad = 1;
    end
    chk("R1/R2/R4 int_en", int_en, e_int);
    chk("R5 ext_en", ext_en, e_ext);
    chk("R3 reg_en", reg_en, e_reg);
    chk("R6 bad_ovl", bad_ovl, e_bad);
    chk("R4 int_page", int_page, e_pg);
    chk("R5 ext_a13", ext_a13, e_a13);
    chk("R1 int_addr", int_addr, e_int ? (a % 'h2000) : 0);
    chk("R5 ext_addr", ext_addr, e_ext ? (a % 'h2000) : 0);
    chk("R3 reg_idx", reg_idx, e_reg ? (a % 32) : 0);
    chk("R9 mem_wr", mem_wr, (wr && (e_int || e_ext || e_reg)) ? 1 : 0);
    chk("R7 onehot", int_en + ext_en + reg_en <= 1, 1);
  end

  task automatic acc(bit dm, int a, bit w);
    @(posedge clk); #1;
    ld_pm = 0; ld_dm = 0; req = 1; space_dm = dm; addr = 14'(a); wr = w;
  endtask

  task automatic load(bit dm, int c);
    @(posedge clk); #1;
    req = 0; ld_pm = !dm; ld_dm = dm; ovl_din = 4'(c);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8: reset codes are 0, so both windows hit internal page 1
    acc(0, 'h2000, 0); acc(1, 'h0000, 1);
    // R1 R2 R3 boundaries
    acc(0, 'h0000, 1); acc(0, 'h1FFF, 0); acc(1, 'h2000, 0); acc(1, 'h3FDF, 1);
    acc(1, 'h3FE0, 1); acc(1, 'h3FFF, 0); acc(1, 'h3FE7, 1);
    // R7 idle
    @(posedge clk); #1 req = 0; addr = 14'h2345; wr = 1;
    // R8/R4/R5/R6: every code, access right after load
    for (int c = 0; c < 16; c++) begin
      load(0, c); acc(0, 'h2ABC, c[0]); acc(1, 'h0123, 0); acc(0, 'h3FFF, 1);
      load(1, 15 - c); acc(1, 'h1FFF, 1); acc(0, 'h1234, 0); acc(1, 'h3FE5, 0);
      acc(1, 'h0000, 0);
    end
    for (int i = 0; i < 200; i++) begin
      if (i % 7 == 0) load(i % 2, (i / 7) % 6);
      acc(i % 3 == 0, (i * 977) % 16384, i % 2);
    end
    @(posedge clk); #1 req = 0;
    @(posedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule